// File: doc/BRIEF.md
# Event-Qualified Counter Capture Unit

This block latches a running counter value when selected events fire. Eight raw event lines come in alongside a small state number. Each event has an enable mask with one bit for every possible state, and the event passes through only when the bit chosen by the current state is set. Eight capture channels then watch the qualified events. Each channel has a control word with two event-select fields. A selected qualified event copies the counter into that channel's capture register.

A mode input chooses how the counter is handled. In unified mode the 32-bit counter is captured whole, and only the low select field of each control word applies. In split mode the counter is two separate 16-bit halves. The low field loads the low half of the capture register, and the high field loads the high half. A simple register port with half-word write enables gives access to the masks and control words, and it reads back the captured values.

Top module: `evcap_unit`

## Requirements
- R1: After reset, every mask, control word and capture register reads back as 0, so nothing is captured until software programs the unit.
- R2: Event m is qualified in a cycle only when ev_in[m] is 1 and bit `state` of event m's 32-bit mask is 1. The state input is 5 bits wide.
- R3: An event whose mask is all zeros never causes a capture, whatever the state.
- R4: With unify=1, a qualified event m whose bit m (bits 7:0) is set in a channel's control word loads the full cnt_val into that channel's capture register at the next clock edge. Bits 23:16 have no effect in this mode.
- R5: With unify=0, bit m of the control word loads capture bits 15:0 from cnt_val[15:0], and bit 16+m loads capture bits 31:16 from cnt_val[31:16]. The two halves load independently at the next clock edge, and a half that is not selected holds its value.
- R6: Control-word bits 15:8 and 31:24 are not stored and always read back as 0.
- R7: A write updates bits 15:0 of the target when wr_half[0]=1 and bits 31:16 when wr_half[1]=1. Both halves can be written in one cycle. This applies to masks and control words alike.
- R8: When several selected events are qualified in one cycle, the capture register loads once, with that cycle's counter value.
- R9: Capture registers cannot be written from the register port. With no raw event active, every capture register holds its value.
- R10: Address bits 4:3 select the register group: 0 for event masks, 1 for control words, 2 for capture registers, and 3 for an empty group that reads 0. Bits 2:0 give the event or channel index. Writes take effect at the next clock edge, and rd_data is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| unify | input | 1 | 1: one 32-bit capture; 0: two independent 16-bit halves |
| cnt_val | input | 32 | Current counter value |
| state | input | 5 | Current state number, used to index the masks |
| ev_in | input | 8 | Raw event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_half | input | 2 | Half-word enables: bit 0 for bits 15:0, bit 1 for bits 31:16 |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: eight events, eight channels and a 5-bit state, which gives 32-bit masks. At these sizes every mask bit, every select bit and every read address is reachable. A long pseudo-random phase can therefore switch modes, change state, overlap events and write to any group, including the capture group that must stay read-only. Directed steps before that phase cover the half-word writes, the reserved bits, masks that are all zeros, state-dependent qualification and several events arriving in the same cycle.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    GRP_MASK = 2'd0,
    GRP_CTRL = 2'd1,
    GRP_CAPT = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;
endpackage

// File: rtl/evcap_rst_sync.sv
module evcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/evcap_qualify.sv
module evcap_qualify #(
  parameter int NUM_EV = 8,
  parameter int ST_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_EV-1:0]           we,
  input  logic [1:0]                  wr_half,
  input  logic [evcap_pkg::DATA_W-1:0] wr_data,
  input  logic [ST_W-1:0]             state,
  input  logic [NUM_EV-1:0]           ev_in,
  output logic [(1<<ST_W)-1:0]        mask_o [NUM_EV],
  output logic [NUM_EV-1:0]           qual_o
);
  localparam int NST = 1 << ST_W;

  logic [NST-1:0] mask_q [NUM_EV];
  logic [NST-1:0] mask_d [NUM_EV];

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    always_comb begin
      mask_d[e] = mask_q[e];
      for (int b = 0; b < NST; b++) begin
        if (wr_half[b / evcap_pkg::HALF_W]) mask_d[e][b] = wr_data[b];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q[e] <= '0;
      else if (we[e]) mask_q[e] <= mask_d[e];
    end

    assign qual_o[e] = ev_in[e] & mask_q[e][state];
    assign mask_o[e] = mask_q[e];
  end
endmodule

// File: rtl/evcap_chan.sv
module evcap_chan #(
  parameter int NUM_EV = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         unify,
  input  logic [NUM_EV-1:0]            qual,
  input  logic [evcap_pkg::DATA_W-1:0] cnt_val,
  input  logic                         ctl_we,
  input  logic [1:0]                   wr_half,
  input  logic [evcap_pkg::DATA_W-1:0] wr_data,
  output logic [evcap_pkg::DATA_W-1:0] ctl_o,
  output logic [evcap_pkg::DATA_W-1:0] cap_o,
  output logic                         lo_hit,
  output logic                         hi_hit
);
  localparam int DW = evcap_pkg::DATA_W;
  localparam int HW = evcap_pkg::HALF_W;

  logic [NUM_EV-1:0] lo_sel_q, lo_sel_d, hi_sel_q, hi_sel_d;
  logic [DW-1:0]     cap_q, cap_d;
  logic              cap_en;

  always_comb begin
    lo_sel_d = lo_sel_q;
    hi_sel_d = hi_sel_q;
    if (wr_half[0]) lo_sel_d = wr_data[NUM_EV-1:0];
    if (wr_half[1]) hi_sel_d = wr_data[HW +: NUM_EV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_sel_q <= '0;
      hi_sel_q <= '0;
    end else if (ctl_we) begin
      lo_sel_q <= lo_sel_d;
      hi_sel_q <= hi_sel_d;
    end
  end

  assign lo_hit = |(qual & lo_sel_q);
  assign hi_hit = (|(qual & hi_sel_q)) & ~unify;
  assign cap_en = lo_hit | hi_hit;

  always_comb begin
    cap_d = cap_q;
    if (unify) begin
      if (lo_hit) cap_d = cnt_val;
    end else begin
      if (lo_hit) cap_d[HW-1:0]  = cnt_val[HW-1:0];
      if (hi_hit) cap_d[DW-1:HW] = cnt_val[DW-1:HW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[NUM_EV-1:0]  = lo_sel_q;
    ctl_o[HW +: NUM_EV] = hi_sel_q;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
  import evcap_pkg::*;
#(
  parameter int NUM_EV = 8,
  parameter int NUM_CH = 8,
  parameter int ST_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unify,
  input  logic [31:0]       cnt_val,
  input  logic [ST_W-1:0]   state,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_half,
  input  logic [4:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [4:0]        rd_addr,
  output logic [31:0]       rd_data
);
  localparam int NST = 1 << ST_W;

  logic              rst_sync_n;
  logic [NST-1:0]    mask_arr [NUM_EV];
  logic [31:0]       ctl_arr  [NUM_CH];
  logic [31:0]       cap_arr  [NUM_CH];
  logic [NUM_EV-1:0] qual_v;
  logic [NUM_EV-1:0] mask_we;
  logic [NUM_CH-1:0] ctl_we;
  logic [NUM_CH-1:0] lo_hit_v, hi_hit_v;
  grp_e              wr_grp, rd_grp;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  evcap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign wr_grp = grp_e'(wr_addr[4:3]);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_grp = grp_e'(rd_addr[4:3]);
  assign rd_idx = rd_addr[IDX_W-1:0];

  for (genvar e = 0; e < NUM_EV; e++) begin : g_mwe
    assign mask_we[e] = wr_en && (wr_grp == GRP_MASK) && (wr_idx == IDX_W'(e));
  end

  evcap_qualify #(.NUM_EV(NUM_EV), .ST_W(ST_W)) u_qual (
    .clk(clk), .rst_n(rst_sync_n), .we(mask_we), .wr_half(wr_half),
    .wr_data(wr_data), .state(state), .ev_in(ev_in),
    .mask_o(mask_arr), .qual_o(qual_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctl_we[c] = wr_en && (wr_grp == GRP_CTRL) && (wr_idx == IDX_W'(c));
    evcap_chan #(.NUM_EV(NUM_EV)) u_chan (
      .clk(clk), .rst_n(rst_sync_n), .unify(unify), .qual(qual_v),
      .cnt_val(cnt_val), .ctl_we(ctl_we[c]), .wr_half(wr_half),
      .wr_data(wr_data), .ctl_o(ctl_arr[c]), .cap_o(cap_arr[c]),
      .lo_hit(lo_hit_v[c]), .hi_hit(hi_hit_v[c])
    );
  end

  always_comb begin
    rd_data = '0;
    case (rd_grp)
      GRP_MASK: for (int e = 0; e < NUM_EV; e++)
                  if (rd_idx == IDX_W'(e)) rd_data = 32'(mask_arr[e]);
      GRP_CTRL: for (int c = 0; c < NUM_CH; c++)
                  if (rd_idx == IDX_W'(c)) rd_data = ctl_arr[c];
      GRP_CAPT: for (int c = 0; c < NUM_CH; c++)
                  if (rd_idx == IDX_W'(c)) rd_data = cap_arr[c];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/evcap_unit_checker.sv
module evcap_unit_checker #(
  parameter int NUM_EV = 8,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unify,
  input logic [31:0]       cnt_val,
  input logic [NUM_EV-1:0] ev_in,
  input logic [31:0]       cap [NUM_CH],
  input logic [NUM_CH-1:0] lo_hit,
  input logic [NUM_CH-1:0] hi_hit
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r4_unified_load: assert property (@(posedge clk) disable iff (!rst_n)
      (unify && lo_hit[c]) |=> (cap[c] == $past(cnt_val)));
    a_r4_unified_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (unify && !lo_hit[c]) |=> $stable(cap[c]));
    a_r5_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      (!unify && lo_hit[c]) |=> (cap[c][15:0] == $past(cnt_val[15:0])));
    a_r5_high_half: assert property (@(posedge clk) disable iff (!rst_n)
      (!unify && hi_hit[c]) |=> (cap[c][31:16] == $past(cnt_val[31:16])));
    a_r5_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!unify && !hi_hit[c]) |=> $stable(cap[c][31:16]));
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in == '0) |=> $stable(cap[c]));
  end
endmodule

bind evcap_unit evcap_unit_checker #(.NUM_EV(NUM_EV), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .unify(unify), .cnt_val(cnt_val),
  .ev_in(ev_in), .cap(cap_arr), .lo_hit(lo_hit_v), .hi_hit(hi_hit_v)
);

// File: tb/evcap_unit_bench.sv
`timescale 1ns/1ps
module evcap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unify = 1'b0;
  logic [31:0] cnt = '0;
  logic [4:0]  st = '0;
  logic [7:0]  ev = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wh = '0;
  logic [4:0]  wa = '0;
  logic [31:0] wd = '0;
  logic [4:0]  ra = '0;
  logic [31:0] rd;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_tag = "R1";
  logic [31:0] lfsr = 32'h1ACE_B00C;

  logic [31:0] m_mask [8];
  logic [31:0] m_ctl  [8];
  logic [31:0] m_cap  [8];

  evcap_unit u_evcap_unit (
    .clk(clk), .rst_n(rst_n), .unify(unify), .cnt_val(cnt), .state(st),
    .ev_in(ev), .wr_en(wr_en), .wr_half(wh), .wr_addr(wa), .wr_data(wd),
    .rd_addr(ra), .rd_data(rd)
  );

  always #4 clk = ~clk;

  // Behavioural reference: captures use pre-write programming, then writes apply.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_mask[i] = 0; m_ctl[i] = 0; m_cap[i] = 0;
      end
    end else begin
      for (int c = 0; c < 8; c++) begin
        bit lo, hi;
        lo = 0; hi = 0;
        for (int e = 0; e < 8; e++) begin
          if (ev[e] && m_mask[e][st]) begin
            if (m_ctl[c][e])      lo = 1;
            if (m_ctl[c][16 + e]) hi = 1;
          end
        end
        if (unify) begin
          if (lo) m_cap[c] = cnt;
        end else begin
          if (lo) m_cap[c][15:0]  = cnt[15:0];
          if (hi) m_cap[c][31:16] = cnt[31:16];
        end
      end
      if (wr_en) begin
        for (int b = 0; b < 32; b++) begin
          if (wh[b / 16]) begin
            if (wa[4:3] == 2'd0) m_mask[wa[2:0]][b] = wd[b];
            if (wa[4:3] == 2'd1 && (b % 16) < 8) m_ctl[wa[2:0]][b] = wd[b];
          end
        end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a[4:3])
      2'd0:    return m_mask[a[2:0]];
      2'd1:    return m_ctl[a[2:0]];
      2'd2:    return m_cap[a[2:0]];
      default: return 32'h0;
    endcase
  endfunction

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp;
      exp = model_read(ra);
      total++;
      if (rd !== exp) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", cur_tag, ra, rd, exp);
      end
    end
  end

  task automatic step(input logic u, input logic [7:0] e, input logic [4:0] s,
                      input logic [31:0] cv, input logic we, input logic [1:0] h,
                      input logic [4:0] a, input logic [31:0] d,
                      input logic [4:0] r, input string tag);
    @(negedge clk); #1;
    unify = u; ev = e; st = s; cnt = cv; wr_en = we; wh = h; wa = a; wd = d;
    ra = r; cur_tag = tag;
  endtask

  function automatic string grp_tag(input logic [4:0] a);
    case (a[4:3])
      2'd0:    return "R7";
      2'd1:    return "R6";
      2'd2:    return "R5";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state read back
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd0,  "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd8,  "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd16, "R1");
    // program masks: ev0 in state 0, ev1 in state 2, ev2 all zero for now
    step(0, 0, 0, 0, 1, 2'b11, 5'd0, 32'h0000_0001, 5'd0, "R7");
    step(0, 0, 0, 0, 1, 2'b11, 5'd1, 32'h0000_0004, 5'd1, "R7");
    // R6: reserved control bits dropped
    step(0, 0, 0, 0, 1, 2'b11, 5'd8, 32'hFFFF_FFFF, 5'd8, "R6");
    // R7: half writes to channel 1
    step(0, 0, 0, 0, 1, 2'b01, 5'd9, 32'h0002_0002, 5'd9, "R7");
    step(0, 0, 0, 0, 1, 2'b10, 5'd9, 32'h0004_0004, 5'd9, "R7");
    // R4: unified capture via ev0
    step(1, 8'h01, 0, 32'h1234_5678, 0, 0, 0, 0, 5'd16, "R4");
    // R3: ev2 has zero mask
    step(1, 8'h04, 0, 32'hAAAA_5555, 0, 0, 0, 0, 5'd16, "R3");
    step(1, 8'h04, 5'd31, 32'hAAAA_5556, 0, 0, 0, 0, 5'd16, "R3");
    // R2: ev1 only in state 2
    step(1, 8'h02, 0, 32'h0BAD_0BAD, 0, 0, 0, 0, 5'd16, "R2");
    step(1, 8'h02, 5'd2, 32'h600D_600D, 0, 0, 0, 0, 5'd16, "R2");
    // enable ev2 everywhere, then split captures on channel 1
    step(0, 0, 0, 0, 1, 2'b11, 5'd2, 32'hFFFF_FFFF, 5'd2, "R7");
    step(0, 8'h02, 5'd2, 32'h1111_2222, 0, 0, 0, 0, 5'd17, "R5");
    step(0, 8'h04, 5'd2, 32'h3333_4444, 0, 0, 0, 0, 5'd17, "R5");
    // R4: high field ignored in unified mode
    step(1, 8'h04, 5'd2, 32'h5555_6666, 0, 0, 0, 0, 5'd17, "R4");
    // R8: several events at once
    step(1, 8'h07, 5'd2, 32'hCAFE_F00D, 0, 0, 0, 0, 5'd16, "R8");
    step(0, 8'h07, 5'd2, 32'hBEEF_1234, 0, 0, 0, 0, 5'd16, "R8");
    // R9: capture group is read-only
    step(0, 0, 0, 0, 1, 2'b11, 5'd16, 32'h0000_0000, 5'd16, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd16, "R9");
    // R10: empty group reads zero, write to it has no effect
    step(0, 0, 0, 0, 1, 2'b11, 5'd24, 32'hFFFF_FFFF, 5'd24, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd24, "R10");
    // pseudo-random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2, r3;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; r1 = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; r2 = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; r3 = lfsr;
      step(r1[0], r1[15:8], r1[20:16], r2, (r1[27:24] < 4'd3), r1[29:28],
           r3[4:0], r3 ^ r2, i[4:0], grp_tag(i[4:0]));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd0, "R1");
    @(negedge clk); #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule